// File: doc/BRIEF.md
# Instruction Issue Queue Stage Tracker

This block follows every instruction held in an eight-slot issue queue from dispatch to writeback. Each slot is either free or sits in exactly one of four stages: waiting (some operand latency still unknown), pending (all latencies known but not yet issuable, or operands present while a memory ordering dependency is still open), ready (issuable), and issued (executing until writeback). Each clock the block re-evaluates every occupied slot against per-slot status inputs. It reports which slots advanced this cycle and which slots finished.

Dispatch uses a set of parallel lanes, two by default, with a valid/ready handshake. `disp_ready` depends only on queue occupancy and never on `disp_valid`. A lane transfers when both signals are high. A lane whose valid is high while its ready is low leaves the queue unchanged. Free slots are handed out lowest index first, and the chosen slot index is returned on `disp_slot` in the same cycle. The selection policy for issue lives outside this block and reaches it as a per-slot grant vector.

Top module: `iq_stage_tracker`

## Requirements
- R1: After reset every slot is free, all four occupancy vectors read zero, and every lane of `disp_ready` is high.
- R2: A dispatched entry enters the waiting stage when its operands are not available and its latencies are not all known. It enters the ready stage when its operands are available and its memory dependencies are resolved. In every other case it enters the pending stage. The occupancy vectors show the new stage from the next cycle.
- R3: Lane k of `disp_ready` is high exactly when more than k slots are free. Lane k is assigned the (k+1)-th lowest-index free slot, which is reported on `disp_slot` bits [k*3 +: 3]. A lane with valid high and ready low changes nothing.
- R4: A waiting slot moves to pending when its latencies become known or its operands become available, and its `prom_pend` bit is high in that cycle.
- R5: A waiting slot whose operands are available and whose memory dependencies are resolved in the same cycle goes straight to ready. Both its `prom_pend` and `prom_ready` bits are high in that cycle.
- R6: A pending slot moves to ready and raises `prom_ready` only when its operands are available and its memory dependencies are resolved. A pending slot with operands present but memory unresolved stays pending.
- R7: An issue grant moves a ready slot to issued. A grant to a slot in any other stage is ignored.
- R8: Writeback on an issued slot frees it and raises its `retired` bit in that cycle. Writeback on a slot in any other stage is ignored.
- R9: `disp_to_pend_cnt` equals the number of lanes that transfer in the current cycle and are classed into the pending stage.
- R10: No slot ever shows more than one occupancy bit.
- R11: A transferring lane is only ever given a slot that is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 2 | Per-lane dispatch request |
| disp_ready | output | 2 | Per-lane free-slot availability |
| disp_lat_known | input | 2 | Per lane: all operand latencies known |
| disp_opnd_avail | input | 2 | Per lane: all operands available |
| disp_mem_ok | input | 2 | Per lane: memory dependencies resolved |
| disp_slot | output | 6 | Per-lane assigned slot index, 3 bits per lane |
| disp_to_pend_cnt | output | 2 | Lanes dispatched into pending this cycle |
| ent_lat_known | input | 8 | Per slot: latencies known |
| ent_opnd_avail | input | 8 | Per slot: operands available |
| ent_mem_ok | input | 8 | Per slot: memory dependencies resolved |
| issue_grant | input | 8 | Per-slot issue grant |
| wb_done | input | 8 | Per-slot writeback completion |
| occ_wait | output | 8 | Slots in the waiting stage |
| occ_pend | output | 8 | Slots in the pending stage |
| occ_ready | output | 8 | Slots in the ready stage |
| occ_issued | output | 8 | Slots in the issued stage |
| prom_pend | output | 8 | Slots leaving waiting this cycle |
| prom_ready | output | 8 | Slots becoming ready this cycle |
| retired | output | 8 | Slots completing writeback this cycle |

## Verification
Directed sequences separate the three dispatch classes. They drive a waiting slot whose status resolves fully in one cycle, to tell the single-cycle double promotion apart from a two-step path. Grants and writebacks go to slots in the wrong stage to show that they are ignored, and the queue is filled until back-pressure on each lane can be told apart. A long seeded random phase then drives independent per-slot status bits, grants, writebacks and dispatch requests. Under this load allocation order, two-lane interaction and the pending-dispatch count are compared every cycle against a stage model kept in the bench.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [2:0] {
    SLOT_FREE  = 3'd0,
    SLOT_WAIT  = 3'd1,
    SLOT_PEND  = 3'd2,
    SLOT_READY = 3'd3,
    SLOT_BUSY  = 3'd4
  } slot_stage_e;

  function automatic slot_stage_e entry_class(input logic lat_known,
                                              input logic opnd_avail,
                                              input logic mem_ok);
    if (!opnd_avail && !lat_known) return SLOT_WAIT;
    else if (opnd_avail && mem_ok) return SLOT_READY;
    else                           return SLOT_PEND;
  endfunction
endpackage

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int N_SLOTS = 8,
  parameter int LANES   = 2,
  localparam int IDXW   = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0]       free_vec,
  output logic [LANES-1:0]         lane_ok,
  output logic [LANES*IDXW-1:0]    lane_slot,
  output logic [LANES*N_SLOTS-1:0] lane_onehot
);
  always_comb begin
    int seen;
    seen        = 0;
    lane_slot   = '0;
    lane_onehot = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (free_vec[i]) begin
        for (int k = 0; k < LANES; k++) begin
          if (seen == k) begin
            lane_slot[k*IDXW +: IDXW]      = IDXW'(i);
            lane_onehot[k*N_SLOTS + i]     = 1'b1;
          end
        end
        seen = seen + 1;
      end
    end
    for (int k = 0; k < LANES; k++) lane_ok[k] = (seen > k);
  end
endmodule

// File: rtl/iq_entry.sv
module iq_entry
  import iq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alloc,
  input  slot_stage_e alloc_stage,
  input  logic        lat_known,
  input  logic        opnd_avail,
  input  logic        mem_ok,
  input  logic        grant,
  input  logic        wb_done,
  output slot_stage_e stage,
  output logic        to_pend,
  output logic        to_ready,
  output logic        retire
);
  slot_stage_e nxt;
  logic        issuable;

  always_comb begin
    issuable = opnd_avail && mem_ok;
    to_pend  = (stage == SLOT_WAIT) && (lat_known || opnd_avail);
    to_ready = (to_pend && issuable) || ((stage == SLOT_PEND) && issuable);
    retire   = (stage == SLOT_BUSY) && wb_done;
    nxt      = stage;
    unique case (stage)
      SLOT_WAIT:  if (to_ready) nxt = SLOT_READY;
                  else if (to_pend) nxt = SLOT_PEND;
      SLOT_PEND:  if (to_ready) nxt = SLOT_READY;
      SLOT_READY: if (grant) nxt = SLOT_BUSY;
      SLOT_BUSY:  if (wb_done) nxt = SLOT_FREE;
      default:    nxt = stage;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     stage <= SLOT_FREE;
    else if (alloc) stage <= alloc_stage;
    else            stage <= nxt;
  end
endmodule

// File: rtl/iq_stage_tracker.sv
module iq_stage_tracker
  import iq_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int LANES   = 2,
  localparam int IDXW   = $clog2(N_SLOTS),
  localparam int CNTW   = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        disp_valid,
  output logic [LANES-1:0]        disp_ready,
  input  logic [LANES-1:0]        disp_lat_known,
  input  logic [LANES-1:0]        disp_opnd_avail,
  input  logic [LANES-1:0]        disp_mem_ok,
  output logic [LANES*IDXW-1:0]   disp_slot,
  output logic [CNTW-1:0]         disp_to_pend_cnt,
  input  logic [N_SLOTS-1:0]      ent_lat_known,
  input  logic [N_SLOTS-1:0]      ent_opnd_avail,
  input  logic [N_SLOTS-1:0]      ent_mem_ok,
  input  logic [N_SLOTS-1:0]      issue_grant,
  input  logic [N_SLOTS-1:0]      wb_done,
  output logic [N_SLOTS-1:0]      occ_wait,
  output logic [N_SLOTS-1:0]      occ_pend,
  output logic [N_SLOTS-1:0]      occ_ready,
  output logic [N_SLOTS-1:0]      occ_issued,
  output logic [N_SLOTS-1:0]      prom_pend,
  output logic [N_SLOTS-1:0]      prom_ready,
  output logic [N_SLOTS-1:0]      retired
);
  slot_stage_e               stg       [N_SLOTS];
  slot_stage_e               alloc_stg [N_SLOTS];
  logic [N_SLOTS-1:0]        slot_alloc;
  logic [N_SLOTS-1:0]        free_vec;
  logic [LANES*N_SLOTS-1:0]  lane_onehot;
  logic [LANES-1:0]          fire;
  slot_stage_e               lane_cls  [LANES];

  iq_alloc #(.N_SLOTS(N_SLOTS), .LANES(LANES)) u_alloc (
    .free_vec    (free_vec),
    .lane_ok     (disp_ready),
    .lane_slot   (disp_slot),
    .lane_onehot (lane_onehot)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign fire[k]     = disp_valid[k] && disp_ready[k];
    assign lane_cls[k] = entry_class(disp_lat_known[k], disp_opnd_avail[k], disp_mem_ok[k]);
  end

  always_comb begin
    disp_to_pend_cnt = '0;
    for (int k = 0; k < LANES; k++)
      if (fire[k] && lane_cls[k] == SLOT_PEND)
        disp_to_pend_cnt = disp_to_pend_cnt + CNTW'(1);
  end

  always_comb begin
    for (int i = 0; i < N_SLOTS; i++) begin
      slot_alloc[i] = 1'b0;
      alloc_stg[i]  = SLOT_FREE;
      for (int k = 0; k < LANES; k++) begin
        if (fire[k] && lane_onehot[k*N_SLOTS + i]) begin
          slot_alloc[i] = 1'b1;
          alloc_stg[i]  = lane_cls[k];
        end
      end
    end
  end

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    iq_entry u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc       (slot_alloc[i]),
      .alloc_stage (alloc_stg[i]),
      .lat_known   (ent_lat_known[i]),
      .opnd_avail  (ent_opnd_avail[i]),
      .mem_ok      (ent_mem_ok[i]),
      .grant       (issue_grant[i]),
      .wb_done     (wb_done[i]),
      .stage       (stg[i]),
      .to_pend     (prom_pend[i]),
      .to_ready    (prom_ready[i]),
      .retire      (retired[i])
    );
    assign free_vec[i]   = (stg[i] == SLOT_FREE);
    assign occ_wait[i]   = (stg[i] == SLOT_WAIT);
    assign occ_pend[i]   = (stg[i] == SLOT_PEND);
    assign occ_ready[i]  = (stg[i] == SLOT_READY);
    assign occ_issued[i] = (stg[i] == SLOT_BUSY);
  end
endmodule

// File: rtl/iq_stage_tracker_chk.sv
module iq_stage_tracker_chk #(
  parameter int N_SLOTS = 8,
  parameter int LANES   = 2,
  localparam int IDXW   = $clog2(N_SLOTS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [LANES-1:0]      disp_valid,
  input logic [LANES-1:0]      disp_ready,
  input logic [LANES*IDXW-1:0] disp_slot,
  input logic [N_SLOTS-1:0]    occ_wait,
  input logic [N_SLOTS-1:0]    occ_pend,
  input logic [N_SLOTS-1:0]    occ_ready,
  input logic [N_SLOTS-1:0]    occ_issued,
  input logic [N_SLOTS-1:0]    prom_ready,
  input logic [N_SLOTS-1:0]    issue_grant,
  input logic [N_SLOTS-1:0]    retired
);
  logic [N_SLOTS-1:0] occ_all, overlap, took;
  logic               bad_alloc;

  assign occ_all = occ_wait | occ_pend | occ_ready | occ_issued;
  assign overlap = (occ_wait & (occ_pend | occ_ready | occ_issued)) |
                   (occ_pend & (occ_ready | occ_issued)) | (occ_ready & occ_issued);
  assign took    = occ_ready & issue_grant;

  always_comb begin
    bad_alloc = 1'b0;
    for (int k = 0; k < LANES; k++)
      if (disp_valid[k] && disp_ready[k] && occ_all[disp_slot[k*IDXW +: IDXW]])
        bad_alloc = 1'b1;
  end

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n) overlap == '0); // R10
  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n) !bad_alloc); // R11
  AST_LANE0_AVAIL: assert property (@(posedge clk) disable iff (!rst_n) disp_ready[0] == (occ_all != '1)); // R3
  AST_READY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) (prom_ready & ~(occ_wait | occ_pend)) == '0); // R6
  AST_ISSUE_MOVE: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((occ_issued & $past(took)) == $past(took))); // R7
  AST_RETIRE_FREE: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((occ_all & $past(retired)) == '0)); // R8
endmodule

bind iq_stage_tracker iq_stage_tracker_chk #(.N_SLOTS(N_SLOTS), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_slot(disp_slot), .occ_wait(occ_wait), .occ_pend(occ_pend),
  .occ_ready(occ_ready), .occ_issued(occ_issued), .prom_ready(prom_ready),
  .issue_grant(issue_grant), .retired(retired)
);

// File: tb/tb_iq_stage_tracker.sv
`timescale 1ns/1ps
module tb_iq_stage_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] dv = '0, dlk = '0, dav = '0, dmo = '0, d_rdy, d_cnt;
  logic [5:0] d_slot;
  logic [7:0] elk = '0, eav = '0, emo = '0, gnt = '0, wb = '0;
  logic [7:0] o_w, o_p, o_r, o_i, p_p, p_r, ret;
  int stg [8];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  iq_stage_tracker dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_ready(d_rdy),
    .disp_lat_known(dlk), .disp_opnd_avail(dav), .disp_mem_ok(dmo),
    .disp_slot(d_slot), .disp_to_pend_cnt(d_cnt),
    .ent_lat_known(elk), .ent_opnd_avail(eav), .ent_mem_ok(emo),
    .issue_grant(gnt), .wb_done(wb),
    .occ_wait(o_w), .occ_pend(o_p), .occ_ready(o_r), .occ_issued(o_i),
    .prom_pend(p_p), .prom_ready(p_r), .retired(ret)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // stage codes of the bench model: 0 free, 1 waiting, 2 pending, 3 ready, 4 issued
  function automatic int cls(input logic lk, input logic av, input logic mo);
    if (!av && !lk) return 1;
    if (av && mo) return 3;
    return 2;
  endfunction

  // called just after a falling edge with inputs already set
  task automatic step();
    logic [7:0] e_w, e_p, e_r, e_i, e_pp, e_pr, e_ret;
    logic [1:0] e_rdy;
    int nx [8];
    int sl [2];
    int nf, cnt;
    #1;
    nf = 0; cnt = 0; sl[0] = 0; sl[1] = 0;
    for (int i = 0; i < 8; i++) begin
      e_w[i] = stg[i] == 1; e_p[i] = stg[i] == 2;
      e_r[i] = stg[i] == 3; e_i[i] = stg[i] == 4;
      e_pp[i] = (stg[i] == 1) && (elk[i] || eav[i]);
      e_pr[i] = (e_pp[i] || stg[i] == 2) && eav[i] && emo[i];
      e_ret[i] = (stg[i] == 4) && wb[i];
      nx[i] = stg[i];
      if (stg[i] == 1 && e_pp[i]) nx[i] = e_pr[i] ? 3 : 2;
      if (stg[i] == 2 && e_pr[i]) nx[i] = 3;
      if (stg[i] == 3 && gnt[i]) nx[i] = 4;
      if (stg[i] == 4 && wb[i]) nx[i] = 0;
      if (stg[i] == 0) begin
        if (nf < 2) sl[nf] = i;
        nf++;
      end
    end
    for (int k = 0; k < 2; k++) begin
      e_rdy[k] = nf > k;
      if (dv[k] && e_rdy[k]) begin
        nx[sl[k]] = cls(dlk[k], dav[k], dmo[k]);
        if (nx[sl[k]] == 2) cnt++;
      end
    end
    chk("R2 occ_wait", 32'(o_w), 32'(e_w));
    chk("R2 occ_pend", 32'(o_p), 32'(e_p));
    chk("R2 occ_ready", 32'(o_r), 32'(e_r));
    chk("R2 occ_issued", 32'(o_i), 32'(e_i));
    chk("R4 prom_pend", 32'(p_p), 32'(e_pp));
    chk("R6 prom_ready", 32'(p_r), 32'(e_pr));
    chk("R8 retired", 32'(ret), 32'(e_ret));
    chk("R3 disp_ready", 32'(d_rdy), 32'(e_rdy));
    if (e_rdy[0]) chk("R3 slot lane0", 32'(d_slot[2:0]), 32'(sl[0]));
    if (e_rdy[1]) chk("R3 slot lane1", 32'(d_slot[5:3]), 32'(sl[1]));
    chk("R9 pend count", 32'(d_cnt), 32'(cnt));
    @(posedge clk);
    for (int i = 0; i < 8; i++) stg[i] = nx[i];
  endtask

  task automatic idle();
    dv = '0; elk = '0; eav = '0; emo = '0; gnt = '0; wb = '0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_7A11));
    for (int i = 0; i < 8; i++) stg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 occupancy empty", 32'(o_w | o_p | o_r | o_i), 32'h0);
    chk("R1 all lanes ready", 32'(d_rdy), 32'h3);

    // lane0 -> waiting (slot0), lane1 -> pending (slot1, latency known)
    @(negedge clk); idle();
    dv = 2'b11; dlk = 2'b10; dav = 2'b00; dmo = 2'b00;
    step();
    // slot2 ready-class via lane0, slot3 pending with operands but memory open
    @(negedge clk); idle();
    dv = 2'b11; dlk = 2'b00; dav = 2'b11; dmo = 2'b01;
    step();
    @(negedge clk); idle();
    chk("R2 waiting class", 32'(o_w), 32'h01);
    chk("R2 pending class", 32'(o_p), 32'h0A);
    chk("R2 ready class", 32'(o_r), 32'h04);
    // slot0 resolves fully; grant and writeback aimed at pending slot1
    elk[0] = 1; eav[0] = 1; emo[0] = 1; eav[3] = 1; gnt[1] = 1; wb[1] = 1;
    #1;
    chk("R5 double promotion pend", 32'(p_p[0]), 32'h1);
    chk("R5 double promotion ready", 32'(p_r[0]), 32'h1);
    chk("R6 memory still open", 32'(p_r[3]), 32'h0);
    step();
    @(negedge clk); idle();
    chk("R5 slot0 now ready", 32'(o_r[0]), 32'h1);
    chk("R7 grant to pending ignored", 32'(o_p[1]), 32'h1);
    chk("R8 writeback to pending ignored", 32'(o_p[1]), 32'h1);
    // issue slot0, then fill queue
    gnt[0] = 1; step();
    @(negedge clk); idle();
    chk("R7 ready to issued", 32'(o_i[0]), 32'h1);
    for (int r = 0; r < 3; r++) begin
      dv = 2'b11; dlk = 2'b11; dav = 2'b00; step();
      @(negedge clk); idle();
    end
    #1;
    chk("R3 full queue back-pressure", 32'(d_rdy), 32'h0);
    dv = 2'b11; dlk = 2'b00; step();
    @(negedge clk); idle();
    chk("R3 blocked valid no change", 32'(o_w), 32'h01 & 32'h0);
    wb[0] = 1; #1;
    chk("R8 retire pulse", 32'(ret), 32'h01);
    step();
    @(negedge clk); idle(); #1;
    chk("R3 one slot free", 32'(d_rdy), 32'h1);
    chk("R3 reuse lowest slot", 32'(d_slot[2:0]), 32'h0);

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      dv  = 2'($urandom);
      dlk = 2'($urandom); dav = 2'($urandom); dmo = 2'($urandom);
      elk = 8'($urandom); eav = 8'($urandom); emo = 8'($urandom);
      gnt = 8'($urandom); wb = 8'($urandom) & 8'($urandom);
      step();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule